// File: doc/BRIEF.md
# ATA Taskfile Register Front End

This block is the host-facing register file of an ATA-style drive. A simple register bus (address, write strobe, read strobe, 16-bit data) reaches the eight-bit taskfile registers, the command and status pair, the device-control and alternate-status pair, and a 16-bit PIO data port. Reads of the data port return the word that the sector logic presents in the same cycle, and writes are passed straight through as a strobe with the full word.

The drive's command engine sits behind the block. It supplies the status and error bytes, a completion pulse that raises the interrupt-pending flag, and a reset-done pulse. It receives a one-cycle command-issue pulse with the command byte, a device-control write pulse, the stored taskfile bytes and a soft-reset level. Taskfile and command writes are dropped while the drive reports busy or data-request. Command writes and primary status reads both clear the pending interrupt. The alternate status read leaves the pending interrupt set.

Top module: `ata_regfile_fe`

## Requirements
- R1: Address map: 0 data, 1 feature/error, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 command/status, 8 device-control/alternate-status. When writes are permitted, a write to addresses 1 to 6 stores bus_wdata[7:0] into that register from the next cycle. Reads of addresses 2 to 6 return the stored byte zero-extended to 16 bits.
- R2: Writes are permitted only when status bit 7 (busy) and bit 3 (data request) are both 0. Otherwise writes to addresses 1 to 6 leave the stored bytes unchanged.
- R3: A read of address 1 returns eng_error_i zero-extended, not the stored feature byte. The stored feature byte is visible on tf_feature_o.
- R4: A permitted write to address 7 clears the interrupt-pending flag. In the following cycle it raises cmd_issue_o for exactly one cycle, with cmd_code_o equal to bus_wdata[7:0].
- R5: A write to address 7 while writes are not permitted produces no command pulse and leaves the interrupt-pending flag unchanged.
- R6: A read of address 7 returns the status byte. From the next cycle the interrupt-pending flag is clear.
- R7: A read of address 8 returns the same status byte and leaves the interrupt-pending flag unchanged.
- R8: A write to address 8 stores bus_wdata[7:0] into device control (devctl_o) whether or not writes are permitted. devctl_wr_o pulses for one cycle in the following cycle.
- R9: cmd_done_i sets the interrupt-pending flag from the next cycle. If a clear happens in the same cycle, the set wins. irq_o is the flag ANDed with the inverse of device-control bit 1 (interrupt disable).
- R10: A device-control write with bit 2 (soft reset) at 1 raises soft_rst_o from the next cycle. Status bit 7 then reads as 1 until the cycle after rst_done_i. A new soft-reset write in the same cycle as rst_done_i keeps the reset active.
- R11: Address 0 accesses are combinational. pio_rd_o follows a read strobe and bus_rdata equals pio_rdata_i. pio_wr_o follows a write strobe and pio_wdata_o equals the full 16-bit bus_wdata.
- R12: Reads of addresses 9 and above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| eng_status_i | input | 8 | Status byte from the command engine |
| eng_error_i | input | 8 | Error byte from the command engine |
| cmd_done_i | input | 1 | Command completion, sets interrupt pending |
| rst_done_i | input | 1 | Soft reset finished |
| pio_rdata_i | input | 16 | PIO read word |
| pio_rd_o | output | 1 | PIO read strobe |
| pio_wr_o | output | 1 | PIO write strobe |
| pio_wdata_o | output | 16 | PIO write word |
| cmd_issue_o | output | 1 | One-cycle command issue pulse |
| cmd_code_o | output | 8 | Command byte |
| devctl_wr_o | output | 1 | One-cycle device-control write pulse |
| devctl_o | output | 8 | Device-control byte |
| soft_rst_o | output | 1 | Soft reset in progress |
| irq_o | output | 1 | Interrupt request |
| tf_feature_o | output | 8 | Feature byte |
| tf_count_o | output | 8 | Sector count byte |
| tf_lba0_o | output | 8 | LBA low byte |
| tf_lba1_o | output | 8 | LBA mid byte |
| tf_lba2_o | output | 8 | LBA high byte |
| tf_device_o | output | 8 | Device/head byte |

## Verification
A wrong write permission shows as a taskfile output that changes, or fails to change, one cycle after the write. A wrong interrupt-pending flag shows on irq_o in the cycle after the completion pulse, the status read or the command write, unless interrupt disable hides it. For that reason the bench toggles the disable bit to expose a hidden pending flag. A stuck soft-reset state shows both on soft_rst_o and as the busy bit in every status read. It also blocks every later taskfile write, so the random write phase catches it quickly.

// File: rtl/ata_fe_pkg.sv
package ata_fe_pkg;
  localparam int REG_W    = 8;
  localparam int NUM_TF   = 6;
  localparam int ADR_DATA = 0;
  localparam int ADR_FEAT = 1;
  localparam int ADR_CMD  = 7;
  localparam int ADR_CTL  = 8;
  localparam int ST_BSY   = 7;
  localparam int ST_DRQ   = 3;
  localparam int CTL_NIEN = 1;
  localparam int CTL_SRST = 2;

  function automatic logic wr_permit(input logic [REG_W-1:0] st);
    return !st[ST_BSY] && !st[ST_DRQ];
  endfunction

  function automatic logic [REG_W-1:0] merge_status(input logic [REG_W-1:0] eng,
                                                    input logic srst_busy);
    logic [REG_W-1:0] r;
    r = eng;
    r[ST_BSY] = eng[ST_BSY] | srst_busy;
    return r;
  endfunction
endpackage

// File: rtl/ata_fe_decode.sv
module ata_fe_decode
  import ata_fe_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_data,
  output logic              sel_cmd,
  output logic              sel_ctl,
  output logic [NUM_TF-1:0] sel_tf
);
  assign sel_data = (addr == ADDR_W'(ADR_DATA));
  assign sel_cmd  = (addr == ADDR_W'(ADR_CMD));
  assign sel_ctl  = (addr == ADDR_W'(ADR_CTL));

  for (genvar i = 0; i < NUM_TF; i++) begin : g_tf
    assign sel_tf[i] = (addr == ADDR_W'(ADR_FEAT + i));
  end
endmodule

// File: rtl/ata_fe_taskfile.sv
module ata_fe_taskfile
  import ata_fe_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_TF-1:0]            wr_sel,
  input  logic                         wr_ok,
  input  logic [REG_W-1:0]             wdata,
  output logic [NUM_TF-1:0][REG_W-1:0] regs
);
  for (genvar i = 0; i < NUM_TF; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 regs[i] <= '0;
      else if (wr_sel[i] && wr_ok) regs[i] <= wdata;
    end

    assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && wr_ok) |=> regs[i] == $past(wdata));
    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[i] && !wr_ok) |=> $stable(regs[i]));
  end
endmodule

// File: rtl/ata_fe_intctl.sv
module ata_fe_intctl
  import ata_fe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             clr_i,
  input  logic             ctl_wr_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             rst_done_i,
  output logic             pend_o,
  output logic [REG_W-1:0] ctl_o,
  output logic             srst_busy_o,
  output logic             irq_o
);
  logic srst_req;
  assign srst_req = ctl_wr_i && ctl_wdata_i[CTL_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_o <= 1'b0;
    else if (done_i) pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_o <= '0;
    else if (ctl_wr_i) ctl_o <= ctl_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          srst_busy_o <= 1'b0;
    else if (srst_req)   srst_busy_o <= 1'b1;
    else if (rst_done_i) srst_busy_o <= 1'b0;
  end

  assign irq_o = pend_o && !ctl_o[CTL_NIEN];

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> pend_o);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !done_i) |=> !pend_o);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !done_i) |=> $stable(pend_o));
  assert_srst_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |=> srst_busy_o);
  assert_srst_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_done_i && !srst_req) |=> !srst_busy_o);
endmodule

// File: rtl/ata_regfile_fe.sv
module ata_regfile_fe
  import ata_fe_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        eng_status_i,
  input  logic [7:0]        eng_error_i,
  input  logic              cmd_done_i,
  input  logic              rst_done_i,
  input  logic [DATA_W-1:0] pio_rdata_i,
  output logic              pio_rd_o,
  output logic              pio_wr_o,
  output logic [DATA_W-1:0] pio_wdata_o,
  output logic              cmd_issue_o,
  output logic [7:0]        cmd_code_o,
  output logic              devctl_wr_o,
  output logic [7:0]        devctl_o,
  output logic              soft_rst_o,
  output logic              irq_o,
  output logic [7:0]        tf_feature_o,
  output logic [7:0]        tf_count_o,
  output logic [7:0]        tf_lba0_o,
  output logic [7:0]        tf_lba1_o,
  output logic [7:0]        tf_lba2_o,
  output logic [7:0]        tf_device_o
);
  logic                         sel_data, sel_cmd, sel_ctl;
  logic [NUM_TF-1:0]            sel_tf;
  logic [NUM_TF-1:0][REG_W-1:0] tf_regs;
  logic [REG_W-1:0]             status;
  logic                         wr_ok, srst_busy, pend;
  logic                         cmd_wr_ev, ctl_wr_ev, irq_clr_ev;

  ata_fe_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel_data(sel_data), .sel_cmd(sel_cmd),
    .sel_ctl(sel_ctl), .sel_tf(sel_tf)
  );

  assign status     = merge_status(eng_status_i, srst_busy);
  assign wr_ok      = wr_permit(status);
  assign cmd_wr_ev  = bus_wr && sel_cmd && wr_ok;
  assign ctl_wr_ev  = bus_wr && sel_ctl;
  assign irq_clr_ev = cmd_wr_ev || (bus_rd && sel_cmd);

  ata_fe_taskfile u_tf (
    .clk(clk), .rst_n(rst_n), .wr_sel(sel_tf & {NUM_TF{bus_wr}}),
    .wr_ok(wr_ok), .wdata(bus_wdata[REG_W-1:0]), .regs(tf_regs)
  );

  ata_fe_intctl u_int (
    .clk(clk), .rst_n(rst_n), .done_i(cmd_done_i), .clr_i(irq_clr_ev),
    .ctl_wr_i(ctl_wr_ev), .ctl_wdata_i(bus_wdata[REG_W-1:0]),
    .rst_done_i(rst_done_i), .pend_o(pend), .ctl_o(devctl_o),
    .srst_busy_o(srst_busy), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_issue_o <= 1'b0;
      cmd_code_o  <= '0;
      devctl_wr_o <= 1'b0;
    end else begin
      cmd_issue_o <= cmd_wr_ev;
      devctl_wr_o <= ctl_wr_ev;
      if (cmd_wr_ev) cmd_code_o <= bus_wdata[REG_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_data)                bus_rdata = pio_rdata_i;
    else if (sel_cmd || sel_ctl) bus_rdata = DATA_W'(status);
    else if (sel_tf[0])          bus_rdata = DATA_W'(eng_error_i);
    else begin
      for (int i = 1; i < NUM_TF; i++)
        if (sel_tf[i]) bus_rdata = DATA_W'(tf_regs[i]);
    end
  end

  assign pio_rd_o     = bus_rd && sel_data;
  assign pio_wr_o     = bus_wr && sel_data;
  assign pio_wdata_o  = bus_wdata;
  assign soft_rst_o   = srst_busy;
  assign tf_feature_o = tf_regs[0];
  assign tf_count_o   = tf_regs[1];
  assign tf_lba0_o    = tf_regs[2];
  assign tf_lba1_o    = tf_regs[3];
  assign tf_lba2_o    = tf_regs[4];
  assign tf_device_o  = tf_regs[5];

  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_cmd && wr_ok) |=> cmd_issue_o && cmd_code_o == $past(bus_wdata[7:0]));
  assert_cmd_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_cmd && !wr_ok) |=> !cmd_issue_o);
  assert_altread_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_ctl && !cmd_done_i && !(bus_wr && sel_cmd)) |=> pend == $past(pend));
  assert_devctl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_ctl) |=> devctl_wr_o && devctl_o == $past(bus_wdata[7:0]));
  assert_pio_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pio_rd_o |-> bus_rdata == pio_rdata_i);
  assert_busy_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> !wr_ok);
endmodule

// File: tb/sim_ata_regfile_fe.sv
module sim_ata_regfile_fe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  eng_status_i = '0, eng_error_i = '0;
  logic        cmd_done_i = 1'b0, rst_done_i = 1'b0;
  logic [15:0] pio_rdata_i = '0, pio_wdata_o;
  logic        pio_rd_o, pio_wr_o, cmd_issue_o, devctl_wr_o, soft_rst_o, irq_o;
  logic [7:0]  cmd_code_o, devctl_o;
  logic [7:0]  tf_feature_o, tf_count_o, tf_lba0_o, tf_lba1_o, tf_lba2_o, tf_device_o;

  int total = 0, bad = 0;
  logic        s_pio;
  logic [15:0] s_word;
  logic [7:0]  m_tf[6];
  logic        m_srst = 1'b0;

  always #2 clk = ~clk;

  ata_regfile_fe u0 (.*);

  function automatic logic permit(input logic [7:0] eng, input logic srst);
    return !(eng[7] || srst) && !eng[3];
  endfunction

  function automatic logic [15:0] exp_status(input logic [7:0] eng, input logic srst);
    return {8'h00, eng | (srst ? 8'h80 : 8'h00)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a[3:0]; bus_wdata = d; bus_wr = 1'b1;
    #1; s_pio = pio_wr_o; s_word = pio_wdata_o;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a[3:0]; bus_rd = 1'b1;
    #1; d = bus_rdata; s_pio = pio_rd_o;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done_i = 1'b1;
    @(negedge clk); cmd_done_i = 1'b0;
  endtask

  task automatic check_tf(input string tag);
    check(tag, tf_feature_o, m_tf[0]);
    check(tag, tf_count_o,   m_tf[1]);
    check(tag, tf_lba0_o,    m_tf[2]);
    check(tag, tf_lba1_o,    m_tf[3]);
    check(tag, tf_lba2_o,    m_tf[4]);
    check(tag, tf_device_o,  m_tf[5]);
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) m_tf[i] = 8'h00;
    repeat (3) @(negedge clk);
    // reset state
    check("reset irq", irq_o, 0);
    check("reset cmd_issue", cmd_issue_o, 0);
    check("reset soft_rst", soft_rst_o, 0);
    check("reset devctl", devctl_o, 0);
    check_tf("reset taskfile");
    rst_n = 1'b1;

    // R1: low byte stored, readback zero-extended
    do_wr(2, 16'h12A5); m_tf[1] = 8'hA5;
    check("R1 count out", tf_count_o, 8'hA5);
    do_rd(2, r); check("R1 count read", r, 16'h00A5);

    // R2: busy or data request blocks taskfile writes
    eng_status_i = 8'h80; do_wr(3, 16'h0033);
    check("R2 bsy blocks", tf_lba0_o, 8'h00);
    eng_status_i = 8'h08; do_wr(3, 16'h0033);
    check("R2 drq blocks", tf_lba0_o, 8'h00);
    eng_status_i = 8'h00;

    // R3: feature address reads error byte
    do_wr(1, 16'h005C); m_tf[0] = 8'h5C; eng_error_i = 8'h04;
    do_rd(1, r);
    check("R3 error read", r, 16'h0004);
    check("R3 feature out", tf_feature_o, 8'h5C);

    // R9, R7, R6
    pulse_done();
    check("R9 irq after done", irq_o, 1);
    eng_status_i = 8'h41;
    do_rd(8, r);
    check("R7 alt status value", r, 16'h0041);
    check("R7 alt read keeps irq", irq_o, 1);
    do_rd(7, r);
    check("R6 status value", r, 16'h0041);
    check("R6 status read clears", irq_o, 0);
    eng_status_i = 8'h00;

    // R8 and R9 interrupt disable
    do_wr(8, 16'hFF02);
    check("R8 devctl pulse", devctl_wr_o, 1);
    check("R8 devctl value", devctl_o, 8'h02);
    pulse_done();
    check("R9 nIEN masks", irq_o, 0);
    do_wr(8, 16'h0000);
    check("R9 unmask shows pending", irq_o, 1);

    // R4: command write clears and issues
    do_wr(7, 16'h77EC);
    check("R4 issue pulse", cmd_issue_o, 1);
    check("R4 code", cmd_code_o, 8'hEC);
    check("R4 irq cleared", irq_o, 0);
    @(negedge clk);
    check("R4 single cycle", cmd_issue_o, 0);

    // R5: busy command write ignored; R8 devctl works while busy
    pulse_done();
    eng_status_i = 8'h80;
    do_wr(7, 16'h0020);
    check("R5 no issue", cmd_issue_o, 0);
    check("R5 irq kept", irq_o, 1);
    do_wr(8, 16'h0002);
    check("R8 devctl while busy", devctl_o, 8'h02);
    check("R8 nIEN while busy", irq_o, 0);
    do_wr(8, 16'h0000);
    eng_status_i = 8'h00;

    // R9: set wins over status-read clear
    @(negedge clk); bus_addr = 4'd7; bus_rd = 1'b1; cmd_done_i = 1'b1;
    @(negedge clk); bus_rd = 1'b0; cmd_done_i = 1'b0;
    check("R9 set wins", irq_o, 1);
    do_rd(7, r);
    check("R6 clear after", irq_o, 0);

    // R10: soft reset
    do_wr(8, 16'h0004); m_srst = 1'b1;
    check("R10 soft_rst on", soft_rst_o, 1);
    do_rd(8, r);
    check("R10 busy bit", r, exp_status(8'h00, m_srst));
    do_wr(4, 16'h0099);
    check("R10 R2 write blocked in reset", tf_lba1_o, 8'h00);
    @(negedge clk); rst_done_i = 1'b1;
    @(negedge clk); rst_done_i = 1'b0; m_srst = 1'b0;
    check("R10 soft_rst off", soft_rst_o, 0);
    do_rd(7, r);
    check("R10 busy gone", r, 16'h0000);
    do_wr(8, 16'h0000);

    // R11: PIO data port
    pio_rdata_i = 16'hBEEF;
    do_rd(0, r);
    check("R11 pio read data", r, 16'hBEEF);
    check("R11 pio rd strobe", s_pio, 1);
    do_wr(0, 16'h1234);
    check("R11 pio wr strobe", s_pio, 1);
    check("R11 pio wdata", s_word, 16'h1234);
    check("R11 no taskfile side effect", tf_count_o, m_tf[1]);

    // R12: unmapped addresses
    for (int a = 9; a < 16; a++) begin
      do_rd(a, r);
      check("R12 unmapped read", r, 16'h0000);
    end

    // random taskfile traffic, R1 R2
    for (int it = 0; it < 200; it++) begin
      int a;
      logic [15:0] d;
      logic [7:0] st;
      case ($urandom % 4)
        0: st = 8'h80;
        1: st = 8'h08;
        default: st = 8'h00;
      endcase
      a = 1 + int'($urandom % 6);
      d = 16'($urandom);
      eng_status_i = st;
      do_wr(a, d);
      if (permit(st, m_srst)) m_tf[a-1] = d[7:0];
      check_tf("R1 R2 random write");
      if (a >= 2) begin
        do_rd(a, r);
        check("R1 random readback", r, {8'h00, m_tf[a-1]});
      end
    end
    eng_status_i = 8'h00;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule